// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block watches over software by way of an 8-bit up-counter. The counter advances on ticks from a prescaler, and the prescaler divides the system clock by one of eight powers of two. In watchdog mode, software has to rewrite the counter before it wraps from 0xFF to 0x00. If the counter wraps, the block can raise an interrupt and can send a fixed-length reset pulse to the reset manager. The pulse is either the power-on kind or the manual kind. In interval mode, each wrap is simply a periodic interrupt.

Software reaches three registers through one small register port: control, counter and status. Address 0 is the control register. Bit 7 selects watchdog mode (1) or interval mode (0). Bit 6 enables the timer. Bit 5 enables the interrupt. Bit 4 enables the reset. Bit 3 selects the manual reset kind (1) or the power-on kind (0). Bits 2:0 select the clock. Address 1 is the counter. Address 2 is the status register, and its bit 0 is the overflow flag. Writing address 2 with bit 0 equal to 0 clears the flag. Reads are registered: `rd_data` shows the register at `addr` one clock later.

Top module: `wdt_timer`

## Requirements
- R1: After reset, control, counter and status all read 0x00, and `irq`, `por_rst` and `man_rst` are low.
- R2: While the enable bit (control bit 6) is 0, the counter holds 0x00 and ignores writes. Clearing the enable bit clears the counter to 0x00.
- R3: With the timer enabled, the counter advances once every D clocks. Clock-select codes 0 to 7 give D = 2, 8, 32, 64, 128, 256, 1024 and 4096.
- R4: The counter wraps from 0xFF to 0x00. A wrap sets the status flag (status bit 0). Writing address 2 with bit 0 equal to 0 clears the flag.
- R5: In interval mode (control bit 7 = 0), every wrap gives a one-clock `irq` pulse, whatever the interrupt-enable bit holds. No reset pulse is produced.
- R6: In watchdog mode, a wrap sets the status flag. It gives an `irq` pulse only when control bit 5 is 1.
- R7: In watchdog mode, a wrap starts a reset pulse only when control bit 4 is 1.
- R8: A watchdog reset of the power-on kind (control bit 3 = 0) drives `por_rst` high for exactly 32 clocks. `man_rst` stays low.
- R9: A watchdog reset of the manual kind (control bit 3 = 1) drives `man_rst` high for exactly 512 clocks. `por_rst` stays low.
- R10: A write to the counter while the timer runs restarts the prescaler. The next tick comes a full D clocks after the write.
- R11: `rd_data` returns the register at `addr` one clock after it is selected. The control register reads back as written. Address 3 reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | 2 | Register select: 0 control, 1 counter, 2 status |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | One-clock interrupt pulse on a wrap |
| por_rst | output | 1 | Power-on-kind reset pulse to the reset manager |
| man_rst | output | 1 | Manual-kind reset pulse to the reset manager |

## Verification
The gating assertions compare a reset or interrupt pulse with the control register one clock earlier. They therefore assume that software does not rewrite the control register in the same clock in which an overflow is being turned into a pulse. The stimulus keeps the control register unchanged until several clocks after each expected wrap, and only then disables the timer. No new reset is started while a pulse is still running, so the two reset outputs never overlap.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W = 8;

  typedef struct packed {
    logic       wd_mode;     // 1: watchdog, 0: interval
    logic       run;         // timer enable
    logic       irq_en;
    logic       rst_en;
    logic       rst_manual;  // 1: manual kind, 0: power-on kind
    logic [2:0] clk_sel;
  } wdt_ctrl_t;

  typedef enum logic [1:0] {
    ADDR_CTRL  = 2'd0,
    ADDR_COUNT = 2'd1,
    ADDR_STAT  = 2'd2,
    ADDR_NONE  = 2'd3
  } wdt_addr_e;

  // log2 of the prescaler divisor for each clock-select code
  function automatic int unsigned div_shift(input logic [2:0] code);
    case (code)
      3'd0:    return 1;
      3'd1:    return 3;
      3'd2:    return 5;
      3'd3:    return 6;
      3'd4:    return 7;
      3'd5:    return 8;
      3'd6:    return 10;
      default: return 12;
    endcase
  endfunction
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PRE_W = 12   // must cover the largest shift (12)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       restart_i,
  input  logic [2:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W:0]   one_sh;
  logic [PRE_W-1:0] mask;

  always_comb begin
    one_sh = {{PRE_W{1'b0}}, 1'b1} << wdt_pkg::div_shift(sel_i);
    mask   = one_sh[PRE_W-1:0] - {{(PRE_W-1){1'b0}}, 1'b1};
    tick_o = ((pre_q & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (rst || !en_i || restart_i) pre_q <= '0;
    else                           pre_q <= pre_q + 1'b1;
  end

  // R3: a tick can only come from a prescaler that ran last cycle
  a_r3_tick_needs_run: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> $past(en_i));
  // R10: a restart leaves no tick in the following cycle
  a_r10_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> !tick_o);
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_i,
  input  logic         tick_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o,
  output logic         ovf_o
);
  logic [W-1:0] cnt_q;
  logic         ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= 1'b0;
      if (!en_i)       cnt_q <= '0;
      else if (load_i) cnt_q <= load_val_i;
      else if (tick_i) begin
        cnt_q <= cnt_q + 1'b1;
        ovf_q <= &cnt_q;
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R4: an overflow marks a step from all ones to zero
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    ovf_o |-> (cnt_o == '0) && ($past(cnt_o) == '1));
  // R2: a stopped timer shows a zero count next cycle
  a_r2_stop_clears: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> (cnt_o == '0));
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int LEN = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] left_q;
  logic          pulse_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q  <= '0;
      pulse_q <= 1'b0;
    end else if (start_i) begin
      left_q  <= CW'(LEN - 1);
      pulse_q <= 1'b1;
    end else begin
      pulse_q <= (left_q != '0);
      if (left_q != '0) left_q <= left_q - 1'b1;
    end
  end

  assign pulse_o = pulse_q;

  generate
    if (LEN > 1) begin : g_hold
      // R8 and R9: a pulse never lasts a single clock
      a_r8_pulse_hold: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse_o) |=> pulse_o);
    end
  endgenerate
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int PRE_W   = 12,
  parameter int POR_LEN = 32,
  parameter int MAN_LEN = 512
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_en,
  input  logic [1:0] addr,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  output logic       irq,
  output logic       por_rst,
  output logic       man_rst
);
  import wdt_pkg::*;

  wdt_ctrl_t        ctrl_q;
  logic             stat_q;
  logic             irq_q;
  logic [REG_W-1:0] rd_q;
  logic             tick, ovf;
  logic [REG_W-1:0] cnt;
  logic             wr_ctrl, wr_cnt, wr_stat;
  logic             wd_rst, por_start, man_start;

  assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
  assign wr_cnt  = wr_en && (addr == ADDR_COUNT);
  assign wr_stat = wr_en && (addr == ADDR_STAT);

  wdt_prescaler #(.PRE_W(PRE_W)) pre_i (
    .clk(clk), .rst(rst), .en_i(ctrl_q.run), .restart_i(wr_cnt),
    .sel_i(ctrl_q.clk_sel), .tick_o(tick)
  );

  wdt_counter #(.W(REG_W)) cnt_i (
    .clk(clk), .rst(rst), .en_i(ctrl_q.run), .tick_i(tick),
    .load_i(wr_cnt), .load_val_i(wr_data), .cnt_o(cnt), .ovf_o(ovf)
  );

  assign wd_rst    = ovf && ctrl_q.wd_mode && ctrl_q.rst_en;
  assign por_start = wd_rst && !ctrl_q.rst_manual;
  assign man_start = wd_rst &&  ctrl_q.rst_manual;

  wdt_pulse #(.LEN(POR_LEN)) por_i (
    .clk(clk), .rst(rst), .start_i(por_start), .pulse_o(por_rst)
  );

  wdt_pulse #(.LEN(MAN_LEN)) man_i (
    .clk(clk), .rst(rst), .start_i(man_start), .pulse_o(man_rst)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      stat_q <= 1'b0;
      irq_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wdt_ctrl_t'(wr_data);
      if (ovf)                        stat_q <= 1'b1;
      else if (wr_stat && !wr_data[0]) stat_q <= 1'b0;
      irq_q <= ovf && (!ctrl_q.wd_mode || ctrl_q.irq_en);
      case (addr)
        ADDR_CTRL:  rd_q <= ctrl_q;
        ADDR_COUNT: rd_q <= cnt;
        ADDR_STAT:  rd_q <= {{(REG_W-1){1'b0}}, stat_q};
        default:    rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;
  assign irq     = irq_q;

  // R5 and R6: an interrupt in watchdog mode needs the interrupt enable
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(!ctrl_q.wd_mode || ctrl_q.irq_en));
  // R7: a reset pulse starts only in watchdog mode with the reset enable set
  a_r7_rst_gate: assert property (@(posedge clk) disable iff (rst)
    ($rose(por_rst) || $rose(man_rst)) |-> $past(ctrl_q.wd_mode && ctrl_q.rst_en));
  // R4: the status flag rises only after an overflow
  a_r4_flag_src: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $past(ovf));
  // R5: interrupt pulses last one clock
  a_r5_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
endmodule

// File: tb/wdt_timer_tb.sv
module wdt_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WD_LIMIT   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_data;
  logic       irq, por_rst, man_rst;

  int n_checks = 0;
  int n_bad    = 0;
  int n_irq = 0, n_por = 0, n_man = 0;
  int cycles = 0;
  bit done = 1'b0;

  wdt_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .irq(irq), .por_rst(por_rst), .man_rst(man_rst)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    cycles++;
    if (irq)     n_irq++;
    if (por_rst) n_por++;
    if (man_rst) n_man++;
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a;
    @(posedge clk);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    check("R1 irq", int'(irq), 0);
    check("R1 por_rst", int'(por_rst), 0);
    check("R1 man_rst", int'(man_rst), 0);
    do_read(2'd0, v); check("R1 ctrl", v, 0);
    do_read(2'd1, v); check("R1 count", v, 0);
    do_read(2'd2, v); check("R1 status", v, 0);
  endtask

  task automatic t_disabled;
    logic [7:0] v;
    do_write(2'd1, 8'h55);
    do_read(2'd1, v); check("R2 write ignored when stopped", v, 0);
  endtask

  task automatic t_rate;
    logic [7:0] v;
    do_write(2'd0, 8'h40);
    do_write(2'd1, 8'h10); idle(9);
    do_read(2'd1, v); check("R3 div2", v, 8'h14);
    do_write(2'd0, 8'h41);
    do_write(2'd1, 8'h00); idle(20);
    do_read(2'd1, v); check("R3 div8", v, 2);
    do_write(2'd0, 8'h42);
    do_write(2'd1, 8'h00); idle(70);
    do_read(2'd1, v); check("R3 div32", v, 2);
    do_write(2'd0, 8'h02); idle(1);
    do_read(2'd1, v); check("R2 stop clears count", v, 0);
  endtask

  task automatic t_restart;
    logic [7:0] v;
    do_write(2'd0, 8'h41);
    do_write(2'd1, 8'h00); idle(5);
    do_write(2'd1, 8'h0A); idle(7);
    do_read(2'd1, v); check("R10 no tick before full period", v, 8'h0A);
    do_read(2'd1, v); check("R10 tick after full period", v, 8'h0B);
    do_write(2'd0, 8'h00);
  endtask

  task automatic t_wrap;
    logic [7:0] v;
    do_write(2'd0, 8'h40);
    do_write(2'd1, 8'hFD); idle(6);
    do_read(2'd1, v); check("R4 wrap to zero", v, 0);
    do_read(2'd2, v); check("R4 flag set", v, 1);
    do_write(2'd2, 8'h01);
    do_read(2'd2, v); check("R4 write with bit0=1 keeps flag", v, 1);
    do_write(2'd2, 8'hFE);
    do_read(2'd2, v); check("R4 flag cleared", v, 0);
    do_write(2'd0, 8'h00);
  endtask

  task automatic run_wrap(input logic [7:0] ctrl, input int tail,
                          output int di, output int dp, output int dm);
    int i0, p0, m0;
    i0 = n_irq; p0 = n_por; m0 = n_man;
    do_write(2'd0, ctrl);
    do_write(2'd1, 8'hFE); idle(10);
    do_write(2'd0, ctrl & 8'hBF); idle(tail);
    di = n_irq - i0; dp = n_por - p0; dm = n_man - m0;
  endtask

  task automatic t_interval;
    int di, dp, dm;
    run_wrap(8'h50, 40, di, dp, dm);
    check("R5 interval irq without enable", di, 1);
    check("R5 interval no por", dp, 0);
    check("R5 interval no man", dm, 0);
    do_write(2'd2, 8'h00);
  endtask

  task automatic t_wd_irq;
    int di, dp, dm;
    logic [7:0] v;
    run_wrap(8'hC0, 20, di, dp, dm);
    check("R6 watchdog irq masked", di, 0);
    check("R7 no reset when disabled", dp + dm, 0);
    do_read(2'd2, v); check("R6 flag set when masked", v, 1);
    do_write(2'd2, 8'h00);
    run_wrap(8'hE0, 20, di, dp, dm);
    check("R6 watchdog irq enabled", di, 1);
    check("R7 no reset with irq only", dp + dm, 0);
    do_write(2'd2, 8'h00);
  endtask

  task automatic t_por;
    int di, dp, dm;
    run_wrap(8'hD0, 50, di, dp, dm);
    check("R8 por length", dp, 32);
    check("R8 man quiet", dm, 0);
    check("R6 irq masked with reset", di, 0);
    do_write(2'd2, 8'h00);
  endtask

  task automatic t_man;
    int di, dp, dm;
    run_wrap(8'hD8, 530, di, dp, dm);
    check("R9 man length", dm, 512);
    check("R9 por quiet", dp, 0);
    do_write(2'd2, 8'h00);
  endtask

  task automatic t_readback;
    logic [7:0] v;
    do_write(2'd0, 8'hA5);
    do_read(2'd0, v); check("R11 ctrl readback", v, 8'hA5);
    do_read(2'd3, v); check("R11 unused address", v, 0);
    do_write(2'd0, 8'h00);
  endtask

  initial begin
    while (!done && cycles < WD_LIMIT) @(posedge clk);
    if (!done) begin
      n_checks++; n_bad++;
      $display("FAIL watchdog: actual=%0d expected<%0d cycles", cycles, WD_LIMIT);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_disabled();
    t_rate();
    t_restart();
    t_wrap();
    t_interval();
    t_wd_irq();
    t_por();
    t_man();
    t_readback();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end
endmodule